// File: doc/BRIEF.md
# Shared-command to split-channel AXI4 bridge

This block sits between a master that issues reads and writes over a single command stream and a slave that expects a standard AXI4 interface with separate read-address and write-address channels. Each command carries a direction bit. The bridge steers a write command onto AW and a read command onto AR, and copies address, ID, length, size and burst type unchanged. Write data, write responses and read responses are separate channels and are forwarded independently of the command stream.

Only one address can cross the bridge per clock, because both directions share one command stream. Address issue is the only thing the shared stream limits: any number of reads and writes may be outstanding downstream. The command path can carry a half-rate register that holds one entry and accepts a new command only after the held one has left. The write-data path can carry a fully registered two-entry stage in which ready is also a register. Both stages are chosen by parameters. Responses pass through without registers, and the bridge does not reorder by ID.

Top module: `shcmd_axi_split`

## Requirements
- R1: After reset the downstream AW, AR and W valids are 0, and the upstream command ready and write-data ready are 1.
- R2: A command accepted with `u_cmd_write`=1 appears once on AW with address, ID, length, size and burst equal to the accepted values, and AR valid stays 0 for it.
- R3: A command accepted with `u_cmd_write`=0 appears once on AR with address, ID, length, size and burst equal to the accepted values, and AW valid stays 0 for it.
- R4: AW valid and AR valid are never 1 in the same cycle.
- R5: With the command stage enabled (`CMD_STAGE`=1), the cycle after a command is accepted `u_cmd_ready` is 0. Under a steady stream with the downstream always ready, exactly one command is accepted every two cycles.
- R6: Commands leave in the order they were accepted. While AW (or AR) is valid and not ready, its valid and fields hold, and no further command is accepted.
- R7: Write-data beats reach the downstream W channel in order, with data, strobes and last unchanged, whether or not any write command has been issued.
- R8: With the write-data stage enabled (`W_STAGE`=1), no beat is lost or duplicated when the downstream stalls, and a beat held on W does not change while it waits. With the downstream always ready, one beat is taken per cycle with no upstream wait.
- R9: The write response passes through in the same cycle: the upstream valid, ID and response code equal the downstream ones, and the upstream ready drives the downstream ready.
- R10: The read response passes through in the same cycle: valid, ID, data, response code and last equal the downstream values, and the upstream ready drives the downstream ready.
- R11: Several reads and writes can be issued with no response returned. Four writes and four reads interleaved are all forwarded while B and R stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| u_cmd_valid | input | 1 | Shared command valid |
| u_cmd_ready | output | 1 | Shared command ready |
| u_cmd_write | input | 1 | 1 = write command, 0 = read command |
| u_cmd_addr | input | ADDR_W | Command address |
| u_cmd_id | input | ID_W | Command ID |
| u_cmd_len | input | 8 | Beats minus one |
| u_cmd_size | input | 3 | Bytes per beat, log2 |
| u_cmd_burst | input | 2 | Burst type |
| u_w_valid | input | 1 | Upstream write-data valid |
| u_w_ready | output | 1 | Upstream write-data ready |
| u_w_data | input | DATA_W | Write data |
| u_w_strb | input | DATA_W/8 | Byte strobes |
| u_w_last | input | 1 | Last beat of burst |
| u_b_valid | output | 1 | Write response valid |
| u_b_ready | input | 1 | Write response ready |
| u_b_id | output | ID_W | Write response ID |
| u_b_resp | output | 2 | Write response code |
| u_r_valid | output | 1 | Read response valid |
| u_r_ready | input | 1 | Read response ready |
| u_r_id | output | ID_W | Read response ID |
| u_r_data | output | DATA_W | Read data |
| u_r_resp | output | 2 | Read response code |
| u_r_last | output | 1 | Last read beat |
| d_aw_valid | output | 1 | Write address valid |
| d_aw_ready | input | 1 | Write address ready |
| d_aw_addr | output | ADDR_W | Write address |
| d_aw_id | output | ID_W | Write ID |
| d_aw_len | output | 8 | Write burst length |
| d_aw_size | output | 3 | Write beat size |
| d_aw_burst | output | 2 | Write burst type |
| d_ar_valid | output | 1 | Read address valid |
| d_ar_ready | input | 1 | Read address ready |
| d_ar_addr | output | ADDR_W | Read address |
| d_ar_id | output | ID_W | Read ID |
| d_ar_len | output | 8 | Read burst length |
| d_ar_size | output | 3 | Read beat size |
| d_ar_burst | output | 2 | Read burst type |
| d_w_valid | output | 1 | Downstream write-data valid |
| d_w_ready | input | 1 | Downstream write-data ready |
| d_w_data | output | DATA_W | Downstream write data |
| d_w_strb | output | DATA_W/8 | Downstream strobes |
| d_w_last | output | 1 | Downstream last |
| d_b_valid | input | 1 | Downstream write response valid |
| d_b_ready | output | 1 | Downstream write response ready |
| d_b_id | input | ID_W | Downstream write response ID |
| d_b_resp | input | 2 | Downstream write response code |
| d_r_valid | input | 1 | Downstream read response valid |
| d_r_ready | output | 1 | Downstream read response ready |
| d_r_id | input | ID_W | Downstream read ID |
| d_r_data | input | DATA_W | Downstream read data |
| d_r_resp | input | 2 | Downstream read response code |
| d_r_last | input | 1 | Downstream read last |

## Verification
The two functions that can fall in the same cycle are steering a command onto one address channel and moving write data or responses on the independent channels. A write and a read may also contend for the single command slot. The bench interleaves reads and writes back to back while W beats flow, and it holds AW ready low so that a stalled write address sits beside an otherwise idle AR channel. Results are judged from logs of the downstream handshakes: each command must appear exactly once, on the right channel and in order. AW and AR must never be valid together, and the accept count under a steady stream must equal half the cycles.

// File: rtl/shcmd_axi_split.sv
module shcmd_axi_split #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 2,
  parameter bit CMD_STAGE = 1'b1,
  parameter bit W_STAGE   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                u_cmd_valid,
  output logic                u_cmd_ready,
  input  logic                u_cmd_write,
  input  logic [ADDR_W-1:0]   u_cmd_addr,
  input  logic [ID_W-1:0]     u_cmd_id,
  input  logic [7:0]          u_cmd_len,
  input  logic [2:0]          u_cmd_size,
  input  logic [1:0]          u_cmd_burst,
  input  logic                u_w_valid,
  output logic                u_w_ready,
  input  logic [DATA_W-1:0]   u_w_data,
  input  logic [DATA_W/8-1:0] u_w_strb,
  input  logic                u_w_last,
  output logic                u_b_valid,
  input  logic                u_b_ready,
  output logic [ID_W-1:0]     u_b_id,
  output logic [1:0]          u_b_resp,
  output logic                u_r_valid,
  input  logic                u_r_ready,
  output logic [ID_W-1:0]     u_r_id,
  output logic [DATA_W-1:0]   u_r_data,
  output logic [1:0]          u_r_resp,
  output logic                u_r_last,
  output logic                d_aw_valid,
  input  logic                d_aw_ready,
  output logic [ADDR_W-1:0]   d_aw_addr,
  output logic [ID_W-1:0]     d_aw_id,
  output logic [7:0]          d_aw_len,
  output logic [2:0]          d_aw_size,
  output logic [1:0]          d_aw_burst,
  output logic                d_ar_valid,
  input  logic                d_ar_ready,
  output logic [ADDR_W-1:0]   d_ar_addr,
  output logic [ID_W-1:0]     d_ar_id,
  output logic [7:0]          d_ar_len,
  output logic [2:0]          d_ar_size,
  output logic [1:0]          d_ar_burst,
  output logic                d_w_valid,
  input  logic                d_w_ready,
  output logic [DATA_W-1:0]   d_w_data,
  output logic [DATA_W/8-1:0] d_w_strb,
  output logic                d_w_last,
  input  logic                d_b_valid,
  output logic                d_b_ready,
  input  logic [ID_W-1:0]     d_b_id,
  input  logic [1:0]          d_b_resp,
  input  logic                d_r_valid,
  output logic                d_r_ready,
  input  logic [ID_W-1:0]     d_r_id,
  input  logic [DATA_W-1:0]   d_r_data,
  input  logic [1:0]          d_r_resp,
  input  logic                d_r_last
);

  localparam int STRB_W = DATA_W / 8;
  localparam int CMD_W  = ADDR_W + ID_W + 8 + 3 + 2;
  localparam int WB_W   = DATA_W + STRB_W + 1;

  logic [CMD_W-1:0] in_cmd, q_cmd;
  logic             q_valid, q_write, q_ready;
  logic [WB_W-1:0]  in_w, out_w;

  assign in_cmd = {u_cmd_addr, u_cmd_id, u_cmd_len, u_cmd_size, u_cmd_burst};
  assign in_w   = {u_w_data, u_w_strb, u_w_last};

  generate
    if (CMD_STAGE) begin : g_cmd_half
      logic             held;
      logic             held_wr;
      logic [CMD_W-1:0] held_cmd;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          held     <= 1'b0;
          held_wr  <= 1'b0;
          held_cmd <= '0;
        end else if (held) begin
          if (q_ready) held <= 1'b0;
        end else if (u_cmd_valid) begin
          held     <= 1'b1;
          held_wr  <= u_cmd_write;
          held_cmd <= in_cmd;
        end
      end
      assign u_cmd_ready = !held;
      assign q_valid     = held;
      assign q_write     = held_wr;
      assign q_cmd       = held_cmd;

      assert_one_per_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        u_cmd_valid && u_cmd_ready |=> !u_cmd_ready);
    end else begin : g_cmd_thru
      assign u_cmd_ready = q_ready;
      assign q_valid     = u_cmd_valid;
      assign q_write     = u_cmd_write;
      assign q_cmd       = in_cmd;
    end
  endgenerate

  assign q_ready    = q_write ? d_aw_ready : d_ar_ready;
  assign d_aw_valid = q_valid &  q_write;
  assign d_ar_valid = q_valid & ~q_write;
  assign {d_aw_addr, d_aw_id, d_aw_len, d_aw_size, d_aw_burst} = q_cmd;
  assign {d_ar_addr, d_ar_id, d_ar_len, d_ar_size, d_ar_burst} = q_cmd;

  generate
    if (W_STAGE) begin : g_w_reg
      logic            main_v, side_v;
      logic [WB_W-1:0] main_d, side_d;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          main_v <= 1'b0;
          side_v <= 1'b0;
          main_d <= '0;
          side_d <= '0;
        end else if (d_w_ready || !main_v) begin
          if (side_v) begin
            main_d <= side_d;
            main_v <= 1'b1;
            side_v <= 1'b0;
          end else begin
            main_d <= in_w;
            main_v <= u_w_valid;
          end
        end else if (u_w_valid && !side_v) begin
          side_d <= in_w;
          side_v <= 1'b1;
        end
      end
      assign u_w_ready = !side_v;
      assign d_w_valid = main_v;
      assign out_w     = main_d;
    end else begin : g_w_thru
      assign u_w_ready = d_w_ready;
      assign d_w_valid = u_w_valid;
      assign out_w     = in_w;
    end
  endgenerate

  assign {d_w_data, d_w_strb, d_w_last} = out_w;

  assign u_b_valid = d_b_valid;
  assign u_b_id    = d_b_id;
  assign u_b_resp  = d_b_resp;
  assign d_b_ready = u_b_ready;

  assign u_r_valid = d_r_valid;
  assign u_r_id    = d_r_id;
  assign u_r_data  = d_r_data;
  assign u_r_resp  = d_r_resp;
  assign u_r_last  = d_r_last;
  assign d_r_ready = u_r_ready;

  assert_one_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_aw_valid && d_ar_valid));

  assert_aw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    d_aw_valid && !d_aw_ready |=> d_aw_valid && $stable(d_aw_addr) && $stable(d_aw_id) && $stable(d_aw_len));

  assert_ar_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    d_ar_valid && !d_ar_ready |=> d_ar_valid && $stable(d_ar_addr) && $stable(d_ar_id) && $stable(d_ar_len));

  assert_w_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    d_w_valid && !d_w_ready |=> d_w_valid && $stable(d_w_data) && $stable(d_w_strb) && $stable(d_w_last));

endmodule

// File: tb/sim_shcmd_axi_split.sv
module sim_shcmd_axi_split;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic u_cmd_valid = 0, u_cmd_write = 0;
  logic [31:0] u_cmd_addr = 0;
  logic [1:0] u_cmd_id = 0, u_cmd_burst = 0;
  logic [7:0] u_cmd_len = 0;
  logic [2:0] u_cmd_size = 0;
  logic u_cmd_ready;
  logic u_w_valid = 0, u_w_last = 0, u_w_ready;
  logic [31:0] u_w_data = 0;
  logic [3:0] u_w_strb = 0;
  logic u_b_valid, u_b_ready = 0;
  logic [1:0] u_b_id, u_b_resp;
  logic u_r_valid, u_r_ready = 0, u_r_last;
  logic [1:0] u_r_id, u_r_resp;
  logic [31:0] u_r_data;
  logic d_aw_valid, d_aw_ready = 1;
  logic [31:0] d_aw_addr;
  logic [1:0] d_aw_id, d_aw_burst;
  logic [7:0] d_aw_len;
  logic [2:0] d_aw_size;
  logic d_ar_valid, d_ar_ready = 1;
  logic [31:0] d_ar_addr;
  logic [1:0] d_ar_id, d_ar_burst;
  logic [7:0] d_ar_len;
  logic [2:0] d_ar_size;
  logic d_w_valid, d_w_ready = 1, d_w_last;
  logic [31:0] d_w_data;
  logic [3:0] d_w_strb;
  logic d_b_valid = 0, d_b_ready;
  logic [1:0] d_b_id = 0, d_b_resp = 0;
  logic d_r_valid = 0, d_r_ready, d_r_last = 0;
  logic [1:0] d_r_id = 0, d_r_resp = 0;
  logic [31:0] d_r_data = 0;

  shcmd_axi_split u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [46:0] aw_log [64];
  logic [46:0] ar_log [64];
  logic [36:0] w_log [64];
  int aw_n = 0, ar_n = 0, w_n = 0, acc_n = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (d_aw_valid && d_aw_ready) begin
        aw_log[aw_n % 64] = {d_aw_addr, d_aw_id, d_aw_len, d_aw_size, d_aw_burst};
        aw_n++;
      end
      if (d_ar_valid && d_ar_ready) begin
        ar_log[ar_n % 64] = {d_ar_addr, d_ar_id, d_ar_len, d_ar_size, d_ar_burst};
        ar_n++;
      end
      if (d_w_valid && d_w_ready) begin
        w_log[w_n % 64] = {d_w_data, d_w_strb, d_w_last};
        w_n++;
      end
      if (u_cmd_valid && u_cmd_ready) acc_n++;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [46:0] pk(logic [31:0] a, logic [1:0] id, logic [7:0] l, logic [2:0] s, logic [1:0] b);
    return {a, id, l, s, b};
  endfunction

  task automatic send_cmd(input bit wr, input logic [46:0] c);
    @(negedge clk);
    u_cmd_valid = 1; u_cmd_write = wr;
    {u_cmd_addr, u_cmd_id, u_cmd_len, u_cmd_size, u_cmd_burst} = c;
    #1;
    while (!u_cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle_cmd();
    @(negedge clk); u_cmd_valid = 0;
  endtask

  task automatic send_w(input logic [36:0] b, output int waits);
    waits = 0;
    @(negedge clk);
    u_w_valid = 1; {u_w_data, u_w_strb, u_w_last} = b;
    #1;
    while (!u_w_ready) begin waits++; @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    chk(d_aw_valid == 0, "R1 aw_valid", d_aw_valid, 0);
    chk(d_ar_valid == 0, "R1 ar_valid", d_ar_valid, 0);
    chk(d_w_valid == 0, "R1 w_valid", d_w_valid, 0);
    chk(u_cmd_ready == 1, "R1 cmd_ready", u_cmd_ready, 1);
    chk(u_w_ready == 1, "R1 w_ready", u_w_ready, 1);
  endtask

  task automatic t_writes_r2();
    int b0 = aw_n, r0 = ar_n;
    logic [46:0] e [3];
    e[0] = pk(32'h2000_0000, 2'd1, 8'd0, 3'd2, 2'd1);
    e[1] = pk(32'hF010_0004, 2'd3, 8'd7, 3'd2, 2'd1);
    e[2] = pk(32'h8000_0010, 2'd0, 8'd3, 3'd1, 2'd2);
    foreach (e[i]) send_cmd(1'b1, e[i]);
    idle_cmd(); repeat (3) @(negedge clk);
    chk(aw_n - b0 == 3, "R2 aw count", aw_n - b0, 3);
    chk(ar_n == r0, "R2 ar untouched", ar_n - r0, 0);
    for (int i = 0; i < 3; i++) chk(aw_log[(b0 + i) % 64] == e[i], "R2 aw fields", aw_log[(b0 + i) % 64], e[i]);
  endtask

  task automatic t_reads_r3();
    int b0 = ar_n, a0 = aw_n;
    logic [46:0] e [3];
    e[0] = pk(32'h1234_5678, 2'd2, 8'd15, 3'd2, 2'd1);
    e[1] = pk(32'hFFFF_FFFC, 2'd1, 8'd0, 3'd0, 2'd0);
    e[2] = pk(32'h0000_0000, 2'd3, 8'd255, 3'd2, 2'd2);
    foreach (e[i]) send_cmd(1'b0, e[i]);
    idle_cmd(); repeat (3) @(negedge clk);
    chk(ar_n - b0 == 3, "R3 ar count", ar_n - b0, 3);
    chk(aw_n == a0, "R3 aw untouched", aw_n - a0, 0);
    for (int i = 0; i < 3; i++) chk(ar_log[(b0 + i) % 64] == e[i], "R3 ar fields", ar_log[(b0 + i) % 64], e[i]);
  endtask

  task automatic t_rate_r5();
    int base;
    @(negedge clk);
    u_cmd_valid = 1; u_cmd_write = 0; u_cmd_addr = 32'hA000_0000;
    base = acc_n;
    repeat (20) @(posedge clk);
    @(negedge clk); u_cmd_valid = 0;
    chk(acc_n - base == 10, "R5 accepts in 20 cycles", acc_n - base, 10);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_stall_r6();
    int b0 = aw_n;
    logic [46:0] c = pk(32'h5555_AAA0, 2'd2, 8'd1, 3'd2, 2'd1);
    d_aw_ready = 0;
    send_cmd(1'b1, c);
    @(negedge clk);
    u_cmd_valid = 1; u_cmd_write = 0; u_cmd_addr = 32'h7777_0000; u_cmd_id = 2'd0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(d_aw_valid == 1 && {d_aw_addr, d_aw_id, d_aw_len, d_aw_size, d_aw_burst} == c,
          "R6 aw held", {d_aw_addr, d_aw_id}, {c[46:13]});
      chk(d_ar_valid == 0, "R4 ar idle beside stalled aw", d_ar_valid, 0);
      chk(u_cmd_ready == 0, "R6 no accept while stalled", u_cmd_ready, 0);
    end
    d_aw_ready = 1;
    @(posedge clk);
    send_cmd(1'b0, pk(32'h7777_0000, 2'd0, 8'd0, 3'd2, 2'd1));
    idle_cmd(); repeat (3) @(negedge clk);
    chk(aw_n - b0 == 1 && aw_log[b0 % 64] == c, "R6 stalled write issued once", aw_n - b0, 1);
    chk(ar_log[(ar_n - 1) % 64][46:15] == 32'h7777_0000, "R6 read follows write", ar_log[(ar_n - 1) % 64][46:15], 32'h7777_0000);
  endtask

  task automatic t_mixed_r11();
    int a0 = aw_n, r0 = ar_n;
    logic [46:0] c [8];
    for (int i = 0; i < 8; i++) c[i] = pk(32'h3000_0000 + i * 16, i[1:0], i[7:0], 3'd2, 2'd1);
    for (int i = 0; i < 8; i++) send_cmd(i[0], c[i]);
    idle_cmd(); repeat (3) @(negedge clk);
    chk(aw_n - a0 == 4, "R11 writes outstanding", aw_n - a0, 4);
    chk(ar_n - r0 == 4, "R11 reads outstanding", ar_n - r0, 4);
    chk(u_b_valid == 0 && u_r_valid == 0, "R11 no responses needed", {u_b_valid, u_r_valid}, 0);
    for (int i = 0; i < 4; i++) begin
      chk(ar_log[(r0 + i) % 64] == c[2 * i], "R6 read order", ar_log[(r0 + i) % 64], c[2 * i]);
      chk(aw_log[(a0 + i) % 64] == c[2 * i + 1], "R6 write order", aw_log[(a0 + i) % 64], c[2 * i + 1]);
    end
  endtask

  task automatic t_wdata_r7_r8();
    int b0 = w_n, waits, tot;
    int a0 = aw_n;
    logic [36:0] e [10];
    for (int i = 0; i < 10; i++) e[i] = {32'hC0DE_0000 ^ (i * 32'h0101_0101), 4'(i * 3), i[0]};
    tot = 0;
    fork
      begin
        for (int i = 0; i < 6; i++) begin send_w(e[i], waits); tot += waits; end
        @(negedge clk); u_w_valid = 0;
      end
      begin
        for (int k = 0; k < 14; k++) begin @(negedge clk); d_w_ready = (k % 3 == 2); end
        d_w_ready = 1;
      end
    join
    repeat (6) @(negedge clk);
    chk(w_n - b0 == 6, "R8 no beat lost under stall", w_n - b0, 6);
    for (int i = 0; i < 6; i++) chk(w_log[(b0 + i) % 64] == e[i], "R7 beat order/contents", w_log[(b0 + i) % 64], e[i]);
    chk(aw_n == a0, "R7 data flows without commands", aw_n - a0, 0);
    tot = 0;
    for (int i = 6; i < 10; i++) begin send_w(e[i], waits); tot += waits; end
    @(negedge clk); u_w_valid = 0;
    repeat (3) @(negedge clk);
    chk(tot == 0, "R8 full rate no waits", tot, 0);
    chk(w_n - b0 == 10 && w_log[(b0 + 9) % 64] == e[9], "R8 burst delivered", w_n - b0, 10);
  endtask

  task automatic t_resp_r9_r10();
    @(negedge clk);
    d_b_valid = 1; d_b_id = 2'd2; d_b_resp = 2'b10; u_b_ready = 1;
    d_r_valid = 1; d_r_id = 2'd3; d_r_data = 32'hDEAD_BEEF; d_r_resp = 2'b01; d_r_last = 1; u_r_ready = 0;
    #1;
    chk(u_b_valid == 1 && u_b_id == 2 && u_b_resp == 2'b10, "R9 b forward", {u_b_valid, u_b_id, u_b_resp}, 5'b11010);
    chk(d_b_ready == 1, "R9 b ready back", d_b_ready, 1);
    chk(u_r_valid && u_r_id == 3 && u_r_data == 32'hDEAD_BEEF && u_r_resp == 1 && u_r_last,
        "R10 r forward", u_r_data, 32'hDEAD_BEEF);
    chk(d_r_ready == 0, "R10 r ready back low", d_r_ready, 0);
    @(negedge clk);
    u_b_ready = 0; u_r_ready = 1; d_r_last = 0; d_b_valid = 0;
    #1;
    chk(d_b_ready == 0 && u_b_valid == 0, "R9 b ready low", {d_b_ready, u_b_valid}, 0);
    chk(d_r_ready == 1 && u_r_last == 0, "R10 r ready high, last low", {d_r_ready, u_r_last}, 2'b10);
    @(negedge clk); d_r_valid = 0; u_r_ready = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset_r1();
    t_writes_r2();
    t_reads_r3();
    t_rate_r5();
    t_stall_r6();
    t_mixed_r11();
    t_wdata_r7_r8();
    t_resp_r9_r10();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule